// File: doc/BRIEF.md
# USB OTG B-Device Session Request Sequencer

This block runs the device side of the On-The-Go session request handshake. It times bus idleness from a one-microsecond tick, raising an early-suspend flag and later a suspend flag, and while suspended it asks the PHY to drain VBUS until the PHY reports that the session has ended. Software may then request a new session. The request is taken only when the session-end indication is present and the line has sat in SE0 long enough.

An accepted request first pulses the data line, then drives the charge-VBUS output for a fixed time, and then waits for VBUS. If VBUS turns valid at any point in this sequence, the block records success, raises a sticky change flag and enables the D+ pull-up. If a timeout measured from acceptance runs out first, it records failure and raises the same change flag. All control and status pins are plain levels or single-cycle strobes. No stream interface exists, so no back-pressure applies.

Top module: `usb_srp_seq`

## Requirements
- R1: `early_susp` is 1 once `bus_active` has been low for IDLE_US ticks. Any cycle with `bus_active` high clears it and restarts the count.
- R2: `susp_flag` is 1 once `bus_active` has been low for IDLE_US+SUSP_EXTRA_US ticks. It is cleared like `early_susp`, and it never stands without `early_susp`.
- R3: `dischrg_vbus` is 1 exactly when `susp_flag` is 1, `sess_end` is 0 and no session sequence is running.
- R4: A `srp_req` strobe is accepted only when the block is idle, `sess_end` is 1, and `line_se0` has been high with `bus_active` low for at least SE0_US ticks. Otherwise the strobe is ignored. Acceptance sets `srp_busy` and clears `srp_ok`.
- R5: After acceptance, `dline_pulse` is high for exactly DP_US ticks. It comes before any charging.
- R6: Directly after the data-line pulse, `chrg_vbus` is high for exactly VB_US ticks. The block then waits with both pulse outputs low.
- R7: If `vbus_valid` is 1 while pulsing or waiting, the next edge sets `srp_ok`, sets `srp_chg`, clears `srp_busy` and raises `connect`. This wins over a timeout in the same cycle.
- R8: `connect` stays high while `vbus_valid` is 1. It falls on the edge after `vbus_valid` goes low.
- R9: If TO_US ticks pass after acceptance without a valid VBUS, `srp_busy` and `srp_ok` go to 0, `srp_chg` goes to 1, and all pulse outputs drop.
- R10: `srp_chg` is cleared by a `chg_clr` strobe, which writes 1 to clear it. A set in the same cycle wins.
- R11: An `srp_req` strobe while `srp_busy` is 1 is ignored. The pulse timing and the timeout of the running sequence are not restarted.
- R12: `dischrg_vbus` and `chrg_vbus` are never high together. At most one of `dline_pulse`, `chrg_vbus` and `connect` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| bus_active | input | 1 | Bus activity seen this cycle |
| line_se0 | input | 1 | Both data lines low |
| sess_end | input | 1 | Session-end indication from the PHY |
| vbus_valid | input | 1 | VBUS valid indication from the PHY |
| srp_req | input | 1 | Software strobe requesting a session |
| chg_clr | input | 1 | Software strobe clearing `srp_chg` |
| early_susp | output | 1 | Early-suspend flag |
| susp_flag | output | 1 | Suspend flag |
| dischrg_vbus | output | 1 | Request to the PHY to discharge VBUS |
| dline_pulse | output | 1 | Data-line pulse drive |
| chrg_vbus | output | 1 | VBUS charge drive |
| connect | output | 1 | D+ pull-up enable |
| srp_busy | output | 1 | Session request in progress |
| srp_ok | output | 1 | Session request succeeded |
| srp_chg | output | 1 | Sticky session-request status change |

## Verification
The bound checker tests these rules on every cycle: discharge and charge are never both high, the three drive outputs are mutually exclusive, suspend implies early suspend, discharge only occurs under suspend without session end, charging always follows a data-line pulse, a request is only taken with session end present, every success or failure raises the change flag, and connect falls after VBUS is lost. Some behaviour only the bench scenarios can show. These are the exact tick counts of the idle, SE0, pulse and timeout windows, the ignored early or duplicate requests, the clear strobe, and success arriving in different phases. A tick-level reference model checks them against every output on each clock.

// File: rtl/usb_srp_pkg.sv
package usb_srp_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_DLINE = 3'd1,
    SQ_VCHG  = 3'd2,
    SQ_WAITV = 3'd3,
    SQ_LINK  = 3'd4
  } srp_state_e;
endpackage

// File: rtl/srp_sat_cnt.sv
// Saturating microsecond counter with two threshold flags.
module srp_sat_cnt #(
  parameter int unsigned MID_US = 3000,
  parameter int unsigned LIM_US = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic mid_hit,
  output logic lim_hit
);
  localparam int unsigned W = $clog2(LIM_US + 1);
  localparam logic [W-1:0] MID_V = W'(MID_US);
  localparam logic [W-1:0] LIM_V = W'(LIM_US);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (tick && cnt_q < LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign mid_hit = (cnt_q >= MID_V);
  assign lim_hit = (cnt_q >= LIM_V);
endmodule

// File: rtl/srp_line_mon.sv
// Watches the bus for idleness and for qualified SE0.
module srp_line_mon #(
  parameter int unsigned IDLE_US       = 3000,
  parameter int unsigned SUSP_EXTRA_US = 1000,
  parameter int unsigned SE0_US        = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic bus_active,
  input  logic line_se0,
  output logic early_susp,
  output logic susp_flag,
  output logic se0_qual
);
  localparam int unsigned SUSP_US = IDLE_US + SUSP_EXTRA_US;

  logic se0_unused;

  srp_sat_cnt #(.MID_US(IDLE_US), .LIM_US(SUSP_US)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(bus_active), .tick(us_tick),
    .mid_hit(early_susp), .lim_hit(susp_flag)
  );

  srp_sat_cnt #(.MID_US(SE0_US), .LIM_US(SE0_US)) u_se0 (
    .clk(clk), .rst_n(rst_n), .clr(bus_active || !line_se0), .tick(us_tick),
    .mid_hit(se0_qual), .lim_hit(se0_unused)
  );
endmodule

// File: rtl/srp_seq_fsm.sv
// Pulse sequencer, timeout and status bits.
module srp_seq_fsm
  import usb_srp_pkg::*;
#(
  parameter int unsigned DP_US = 7000,
  parameter int unsigned VB_US = 10000,
  parameter int unsigned TO_US = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       sess_end,
  input  logic       se0_qual,
  input  logic       vbus_valid,
  input  logic       srp_req,
  input  logic       chg_clr,
  output srp_state_e state,
  output logic       srp_busy,
  output logic       srp_ok,
  output logic       srp_chg
);
  localparam int unsigned PMAX = (DP_US > VB_US) ? DP_US : VB_US;
  localparam int unsigned PW   = $clog2(PMAX + 1);
  localparam int unsigned TW   = $clog2(TO_US + 1);
  localparam logic [PW-1:0] DP_END = PW'(DP_US - 1);
  localparam logic [PW-1:0] VB_END = PW'(VB_US - 1);
  localparam logic [TW-1:0] TO_END = TW'(TO_US - 1);

  srp_state_e   st_q, st_d;
  logic [PW-1:0] ph_q;
  logic [TW-1:0] to_q;
  logic accept, pulsing, win, expire, ph_done;

  always_comb begin
    pulsing = (st_q == SQ_DLINE) || (st_q == SQ_VCHG) || (st_q == SQ_WAITV);
    accept  = (st_q == SQ_IDLE) && srp_req && sess_end && se0_qual;
    win     = pulsing && vbus_valid;
    expire  = pulsing && !vbus_valid && us_tick && (to_q == TO_END);
    ph_done = us_tick && (ph_q == ((st_q == SQ_DLINE) ? DP_END : VB_END));
    st_d    = st_q;
    unique case (st_q)
      SQ_IDLE:  if (accept) st_d = SQ_DLINE;
      SQ_DLINE: if (win) st_d = SQ_LINK;
                else if (expire) st_d = SQ_IDLE;
                else if (ph_done) st_d = SQ_VCHG;
      SQ_VCHG:  if (win) st_d = SQ_LINK;
                else if (expire) st_d = SQ_IDLE;
                else if (ph_done) st_d = SQ_WAITV;
      SQ_WAITV: if (win) st_d = SQ_LINK;
                else if (expire) st_d = SQ_IDLE;
      SQ_LINK:  if (!vbus_valid) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      ph_q     <= '0;
      to_q     <= '0;
      srp_busy <= 1'b0;
      srp_ok   <= 1'b0;
      srp_chg  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) ph_q <= '0;
      else if (us_tick && (st_q == SQ_DLINE || st_q == SQ_VCHG)) ph_q <= ph_q + 1'b1;
      if (accept) to_q <= '0;
      else if (pulsing && us_tick && to_q != TO_END) to_q <= to_q + 1'b1;
      if (accept) begin
        srp_busy <= 1'b1;
        srp_ok   <= 1'b0;
      end else if (win) begin
        srp_busy <= 1'b0;
        srp_ok   <= 1'b1;
      end else if (expire) begin
        srp_busy <= 1'b0;
        srp_ok   <= 1'b0;
      end
      if (win || expire) srp_chg <= 1'b1;
      else if (chg_clr)  srp_chg <= 1'b0;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/usb_srp_seq.sv
module usb_srp_seq
  import usb_srp_pkg::*;
#(
  parameter int unsigned IDLE_US       = 3000,
  parameter int unsigned SUSP_EXTRA_US = 1000,
  parameter int unsigned SE0_US        = 2000,
  parameter int unsigned DP_US         = 7000,
  parameter int unsigned VB_US         = 10000,
  parameter int unsigned TO_US         = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic bus_active,
  input  logic line_se0,
  input  logic sess_end,
  input  logic vbus_valid,
  input  logic srp_req,
  input  logic chg_clr,
  output logic early_susp,
  output logic susp_flag,
  output logic dischrg_vbus,
  output logic dline_pulse,
  output logic chrg_vbus,
  output logic connect,
  output logic srp_busy,
  output logic srp_ok,
  output logic srp_chg
);
  srp_state_e state;
  logic       se0_qual;

  srp_line_mon #(
    .IDLE_US(IDLE_US), .SUSP_EXTRA_US(SUSP_EXTRA_US), .SE0_US(SE0_US)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_active(bus_active),
    .line_se0(line_se0), .early_susp(early_susp), .susp_flag(susp_flag),
    .se0_qual(se0_qual)
  );

  srp_seq_fsm #(.DP_US(DP_US), .VB_US(VB_US), .TO_US(TO_US)) u_fsm (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sess_end(sess_end),
    .se0_qual(se0_qual), .vbus_valid(vbus_valid), .srp_req(srp_req),
    .chg_clr(chg_clr), .state(state), .srp_busy(srp_busy),
    .srp_ok(srp_ok), .srp_chg(srp_chg)
  );

  assign dline_pulse  = (state == SQ_DLINE);
  assign chrg_vbus    = (state == SQ_VCHG);
  assign connect      = (state == SQ_LINK);
  assign dischrg_vbus = susp_flag && !sess_end && (state == SQ_IDLE);
endmodule

// File: rtl/srp_seq_chk.sv
module srp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sess_end,
  input logic vbus_valid,
  input logic srp_req,
  input logic early_susp,
  input logic susp_flag,
  input logic dischrg_vbus,
  input logic dline_pulse,
  input logic chrg_vbus,
  input logic connect,
  input logic srp_busy,
  input logic srp_ok,
  input logic srp_chg
);
  a_r12_no_dis_chg: assert property (@(posedge clk) disable iff (!rst_n)
    !(dischrg_vbus && chrg_vbus));
  a_r12_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dline_pulse, chrg_vbus, connect}));
  a_r2_susp_nested: assert property (@(posedge clk) disable iff (!rst_n)
    susp_flag |-> early_susp);
  a_r3_dis_cond: assert property (@(posedge clk) disable iff (!rst_n)
    dischrg_vbus |-> (susp_flag && !sess_end && !srp_busy));
  a_r6_chg_after_dp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrg_vbus) |-> $past(dline_pulse));
  a_r4_accept_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srp_busy) |-> ($past(sess_end) && $past(srp_req) && !srp_ok));
  a_r7_success: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect) |-> (srp_ok && srp_chg && !srp_busy));
  a_r9_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(srp_busy) && !srp_ok) |-> srp_chg);
  a_r8_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    (connect && !vbus_valid) |=> !connect);
endmodule

bind usb_srp_seq srp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sess_end(sess_end), .vbus_valid(vbus_valid),
  .srp_req(srp_req), .early_susp(early_susp), .susp_flag(susp_flag),
  .dischrg_vbus(dischrg_vbus), .dline_pulse(dline_pulse),
  .chrg_vbus(chrg_vbus), .connect(connect), .srp_busy(srp_busy),
  .srp_ok(srp_ok), .srp_chg(srp_chg)
);

// File: tb/usb_srp_seq_tb_top.sv
module usb_srp_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_IDLE = 30, P_EXTRA = 10, P_SE0 = 20;
  localparam int P_DP = 15, P_VB = 25, P_TO = 100;

  logic clk = 0, rst_n = 0, us_tick = 0;
  logic bus_active = 1, line_se0 = 0, sess_end = 0, vbus_valid = 0;
  logic srp_req = 0, chg_clr = 0;
  logic early_susp, susp_flag, dischrg_vbus, dline_pulse, chrg_vbus;
  logic connect, srp_busy, srp_ok, srp_chg;

  int n_run = 0, n_fail = 0, cyc = 0;
  // reference model state
  int m_idle = 0, m_se0 = 0, m_st = 0, m_ph = 0, m_to = 0;
  bit m_busy = 0, m_ok = 0, m_chg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_srp_seq #(
    .IDLE_US(P_IDLE), .SUSP_EXTRA_US(P_EXTRA), .SE0_US(P_SE0),
    .DP_US(P_DP), .VB_US(P_VB), .TO_US(P_TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_active(bus_active),
    .line_se0(line_se0), .sess_end(sess_end), .vbus_valid(vbus_valid),
    .srp_req(srp_req), .chg_clr(chg_clr), .early_susp(early_susp),
    .susp_flag(susp_flag), .dischrg_vbus(dischrg_vbus),
    .dline_pulse(dline_pulse), .chrg_vbus(chrg_vbus), .connect(connect),
    .srp_busy(srp_busy), .srp_ok(srp_ok), .srp_chg(srp_chg)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // tick pattern: two of every three cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 us_tick = ((cyc % 3) != 0);
  end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_idle = 0; m_se0 = 0; m_st = 0; m_ph = 0; m_to = 0;
      m_busy = 0; m_ok = 0; m_chg = 0;
    end else begin
      bit qual, set;
      qual = (m_se0 >= P_SE0);
      set = 0;
      case (m_st)
        0: if (srp_req && sess_end && qual) begin
             m_st = 1; m_ph = 0; m_to = 0; m_busy = 1; m_ok = 0;
           end
        1, 2, 3: begin
          if (vbus_valid) begin
            m_st = 4; m_busy = 0; m_ok = 1; set = 1;
          end else if (us_tick && m_to == P_TO - 1) begin
            m_st = 0; m_busy = 0; m_ok = 0; set = 1;
          end else begin
            if (m_st == 1 && us_tick && m_ph == P_DP - 1) begin m_st = 2; m_ph = 0; end
            else if (m_st == 2 && us_tick && m_ph == P_VB - 1) begin m_st = 3; m_ph = 0; end
            else if (m_st != 3 && us_tick) m_ph++;
            if (us_tick) m_to++;
          end
        end
        default: if (!vbus_valid) m_st = 0;
      endcase
      if (set) m_chg = 1; else if (chg_clr) m_chg = 0;
      if (bus_active) m_idle = 0;
      else if (us_tick && m_idle < P_IDLE + P_EXTRA) m_idle++;
      if (bus_active || !line_se0) m_se0 = 0;
      else if (us_tick && m_se0 < P_SE0) m_se0++;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_susp;
      e_susp = (m_idle >= P_IDLE + P_EXTRA);
      chk("R1 early_susp", early_susp, m_idle >= P_IDLE);
      chk("R2 susp_flag", susp_flag, e_susp);
      chk("R3 dischrg_vbus", dischrg_vbus, e_susp && !sess_end && m_st == 0);
      chk("R4/R11 srp_busy", srp_busy, m_busy);
      chk("R5 dline_pulse", dline_pulse, m_st == 1);
      chk("R6 chrg_vbus", chrg_vbus, m_st == 2);
      chk("R7 srp_ok", srp_ok, m_ok);
      chk("R8 connect", connect, m_st == 4);
      chk("R10 srp_chg", srp_chg, m_chg);
      chk("R12 dis_and_chg", dischrg_vbus && chrg_vbus, 1'b0);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog R1..R12 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic strobe_req();
    srp_req = 1; step(1); srp_req = 0;
  endtask

  task automatic strobe_clr();
    chg_clr = 1; step(1); chg_clr = 0;
  endtask

  initial begin
    #1;
    chk("reset early_susp", early_susp, 1'b0);
    chk("reset connect", connect, 1'b0);
    chk("reset srp_chg", srp_chg, 1'b0);
    step(3); rst_n = 1;
    step(10);
    bus_active = 0; step(80);            // R1 R2 R3 idle to suspend
    chk("R3 discharge on", dischrg_vbus, 1'b1);
    bus_active = 1; step(1); bus_active = 0; step(1);   // R1 restart
    chk("R1 cleared by activity", early_susp, 1'b0);
    step(80);
    sess_end = 1; step(1);
    chk("R3 discharge off at session end", dischrg_vbus, 1'b0);
    line_se0 = 1; strobe_req(); step(1);  // R4 too early
    chk("R4 early request ignored", srp_busy, 1'b0);
    step(40);
    strobe_req(); step(1);
    chk("R5 pulse after accept", dline_pulse, 1'b1);
    step(5); strobe_req();                // R11 duplicate
    for (int i = 0; i < 400 && srp_busy; i++) step(1);
    chk("R9 timeout ok low", srp_ok, 1'b0);
    chk("R9 timeout chg set", srp_chg, 1'b1);
    strobe_clr(); step(1);
    chk("R10 cleared", srp_chg, 1'b0);
    strobe_req();
    for (int i = 0; i < 200 && !chrg_vbus; i++) step(1);
    step(5); vbus_valid = 1; step(2);
    chk("R7 connect", connect, 1'b1);
    chk("R7 ok", srp_ok, 1'b1);
    step(10); vbus_valid = 0; step(2);
    chk("R8 disconnect", connect, 1'b0);
    strobe_clr(); step(2);
    strobe_req(); step(3);                 // R7 win during data-line pulse
    vbus_valid = 1; chg_clr = 1; step(1); chg_clr = 0; step(1);
    chk("R10 set beats clear", srp_chg, 1'b1);
    vbus_valid = 0; step(3);
    sess_end = 0; strobe_req(); step(2);
    chk("R4 no session end ignored", srp_busy, 1'b0);
    step(5);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule